// File: doc/BRIEF.md
# Configuration Image Loader with CRC Retry

After power-on this block reads a configuration image out of a one-time-programmable memory, one byte per cycle, through a synchronous read port. It runs a CRC-16 over the payload bytes and compares the result with a check value stored in the image's last two bytes. If the two do not match, the block reads and checks the whole image again. It stops retrying as soon as a check passes, or after eight attempts in total.

A failed check does not stop the block. It then copies the payload bytes into the configuration registers through a write port and raises `done` for one cycle. A status register records how many attempts failed and whether every attempt failed. These fields hold their values until power-on reset or a software reset. A software reset also restarts the whole sequence from the first attempt.

The block runs once per power-up or software reset. Software reads the status register afterwards to decide whether to trust the loaded configuration.

Top module: `cfg_image_loader`

## Requirements
- R1: While reset is applied, `done` and `cfg_wr_en` are 0 and the status register reads 0x00.
- R2: The check value is CRC-16 with polynomial 0x1021 and start value 0xFFFF. It is computed MSB first, with no final inversion, over bytes 0 to WORDS-3. It is compared with the 16-bit value {byte WORDS-2, byte WORDS-1}, where byte WORDS-2 is the high byte.
- R3: Read data is valid one cycle after `mem_rd_en`. Each check attempt reads addresses 0 to WORDS-1 in ascending order, and the CRC changes only on cycles that carry valid payload data.
- R4: During the check attempts no configuration write is issued. The load phase writes each byte 0 to WORDS-3 exactly once, in ascending order, with `cfg_wr_addr` equal to the byte index and `cfg_wr_data` equal to the stored byte.
- R5: A passing check ends the retries at once. The load then starts, the flag stays 0, and the count equals the number of failed attempts before the pass.
- R6: At most eight attempts are made. If all eight fail, the image is still loaded, the count reads 7 and the flag reads 1. The flag is never 1 while the count is below 7.
- R7: Reading status address 0x0FE returns the failure count in bits [7:5], zeros in bits [4:1] and the flag in bit 0. Every other status address reads 0x00.
- R8: `done` is high for exactly one cycle, one cycle after the final configuration write. After that, no further writes occur and `done` stays low until the next restart.
- R9: A one-cycle `sw_reset` pulse clears the count and the flag on the next clock edge and restarts the sequence from the first attempt.
- R10: Apart from `sw_reset` and power-on reset, the count never decreases and a set flag never clears, including after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_reset | input | 1 | Synchronous software reset: clears status, restarts load |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Memory read data, valid one cycle after the strobe |
| cfg_wr_en | output | 1 | Configuration register write strobe |
| cfg_wr_addr | output | AW | Configuration register index |
| cfg_wr_data | output | 8 | Configuration register data |
| stat_rd_addr | input | 9 | Status register read address |
| stat_rd_data | output | 8 | Status register read data (combinational) |
| done | output | 1 | One-cycle pulse when the load completes |

## Verification
The assertions check several properties on every cycle: writes and reads stay inside the image, every write follows a read, and `done` is a single-cycle pulse. They also check that the count only grows, that the flag is sticky and appears only at the saturated count, and that the CRC holds when no valid data arrives. Some behaviour only the bench scenarios can show. These are the CRC arithmetic itself, the exact number of retries for a given number of corrupted reads, and the bytes and order of the load. They also include the retries being abandoned after eight failures and a software reset clearing status and restarting the sequence mid-run.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_START, ST_CHECK, ST_DRAIN, ST_EVAL,
    ST_LOAD,  ST_TAIL,  ST_FINI,  ST_PARK
  } ld_state_t;

  // One byte through the CRC, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgl_crc16.sv
module cfgl_crc16
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] crc_n;

  always_comb begin
    crc_n = crc;
    if (clear)    crc_n = CRC_SEED;
    else if (upd) crc_n = crc_step(crc, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= CRC_SEED;
    else        crc <= crc_n;
  end

  // R3: no change without valid payload data
  a_r3_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clear) |=> $stable(crc));

endmodule

// File: rtl/cfgl_status.sv
module cfgl_status #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fail_ev,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             last_try
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_n;
  logic             flag_n;

  assign last_try = (cnt == CNT_MAX);

  always_comb begin
    cnt_n  = cnt;
    flag_n = flag;
    if (clr) begin
      cnt_n  = '0;
      flag_n = 1'b0;
    end else if (fail_ev) begin
      if (last_try) flag_n = 1'b1;
      else          cnt_n  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      flag <= flag_n;
    end
  end

  a_r6_flag_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (cnt == CNT_MAX));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r10_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !flag));

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfgl_pkg::*;
#(
  parameter int          WORDS     = 16,
  parameter int          CNT_W     = 3,
  parameter int          STAT_AW   = 9,
  parameter logic [8:0]  STAT_ADDR = 9'h0FE,
  localparam int         AW        = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_reset,
  output logic               mem_rd_en,
  output logic [AW-1:0]      mem_addr,
  input  logic [BYTE_W-1:0]  mem_rd_data,
  output logic               cfg_wr_en,
  output logic [AW-1:0]      cfg_wr_addr,
  output logic [BYTE_W-1:0]  cfg_wr_data,
  input  logic [STAT_AW-1:0] stat_rd_addr,
  output logic [BYTE_W-1:0]  stat_rd_data,
  output logic               done
);

  localparam logic [AW-1:0] LAST_W = AW'(WORDS - 1);
  localparam logic [AW-1:0] HI_W   = AW'(WORDS - 2);
  localparam logic [AW-1:0] LAST_D = AW'(WORDS - 3);
  localparam int            PAD_W  = BYTE_W - CNT_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic rs_q1, rs_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i = rs_q2;

  ld_state_t         state, state_n;
  logic [AW-1:0]     addr, addr_n;
  logic              vld;
  logic [AW-1:0]     vaddr;
  logic [BYTE_W-1:0] exp_hi, exp_lo;
  logic              rd_en, crc_clr, crc_upd, fail_ev, checking, loading;
  logic [CRC_W-1:0]  crc;
  logic [CNT_W-1:0]  fcnt;
  logic              fflag, last_try;

  assign checking = (state == ST_CHECK) || (state == ST_DRAIN);
  assign loading  = (state == ST_LOAD)  || (state == ST_TAIL);

  always_comb begin
    state_n = state;
    addr_n  = addr;
    rd_en   = 1'b0;
    crc_clr = 1'b0;
    fail_ev = 1'b0;
    case (state)
      ST_START: begin
        crc_clr = 1'b1;
        addr_n  = '0;
        state_n = ST_CHECK;
      end
      ST_CHECK: begin
        rd_en = 1'b1;
        if (addr == LAST_W) begin
          addr_n  = '0;
          state_n = ST_DRAIN;
        end else begin
          addr_n = addr + 1'b1;
        end
      end
      ST_DRAIN: state_n = ST_EVAL;
      ST_EVAL: begin
        crc_clr = 1'b1;
        addr_n  = '0;
        if (crc == {exp_hi, exp_lo}) begin
          state_n = ST_LOAD;
        end else begin
          fail_ev = 1'b1;
          state_n = last_try ? ST_LOAD : ST_CHECK;
        end
      end
      ST_LOAD: begin
        rd_en = 1'b1;
        if (addr == LAST_D) begin
          addr_n  = '0;
          state_n = ST_TAIL;
        end else begin
          addr_n = addr + 1'b1;
        end
      end
      ST_TAIL: state_n = ST_FINI;
      ST_FINI: state_n = ST_PARK;
      default: state_n = ST_PARK;
    endcase
    if (sw_reset) state_n = ST_START;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state  <= ST_START;
      addr   <= '0;
      vld    <= 1'b0;
      vaddr  <= '0;
      exp_hi <= '0;
      exp_lo <= '0;
    end else begin
      state <= state_n;
      addr  <= addr_n;
      vld   <= rd_en && !sw_reset;
      if (rd_en) vaddr <= addr;
      if (vld && checking && vaddr == HI_W)   exp_hi <= mem_rd_data;
      if (vld && checking && vaddr == LAST_W) exp_lo <= mem_rd_data;
    end
  end

  assign crc_upd = vld && checking && (vaddr <= LAST_D);

  cfgl_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_i),
    .clear (crc_clr),
    .upd   (crc_upd),
    .din   (mem_rd_data),
    .crc   (crc)
  );

  cfgl_status #(.CNT_W(CNT_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (sw_reset),
    .fail_ev  (fail_ev),
    .cnt      (fcnt),
    .flag     (fflag),
    .last_try (last_try)
  );

  assign mem_rd_en    = rd_en;
  assign mem_addr     = addr;
  assign cfg_wr_en    = vld && loading;
  assign cfg_wr_addr  = vaddr;
  assign cfg_wr_data  = mem_rd_data;
  assign done         = (state == ST_FINI);
  assign stat_rd_data = (stat_rd_addr == STAT_ADDR) ? {fcnt, {PAD_W{1'b0}}, fflag}
                                                    : '0;

  a_r3_rd_in_image: assert property (@(posedge clk) disable iff (!rst_i)
    mem_rd_en |-> (mem_addr <= LAST_W));
  a_r4_wr_in_payload: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_wr_en |-> (cfg_wr_addr <= LAST_D));
  a_r4_wr_after_read: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_wr_en |-> $past(mem_rd_en));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);
  a_r8_no_wr_at_done: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> !cfg_wr_en);

endmodule

// File: tb/cfg_image_loader_test.sv
module cfg_image_loader_test;

  localparam int WORDS = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n, sw_reset;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rd_data;
  logic          cfg_wr_en;
  logic [AW-1:0] cfg_wr_addr;
  logic [7:0]    cfg_wr_data;
  logic [8:0]    stat_rd_addr;
  logic [7:0]    stat_rd_data;
  logic          done;

  always #5 clk = ~clk;

  cfg_image_loader #(.WORDS(WORDS)) uut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .stat_rd_addr(stat_rd_addr), .stat_rd_data(stat_rd_data), .done(done)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] img [WORDS];
  int k_fail = 0, passes = 0, exp_att = 1, wr_idx = 0;
  logic [7:0] rdq = 8'h00;

  // memory model, one-cycle latency; byte 0 corrupted on the first k_fail passes
  always @(posedge clk) begin
    if (sw_reset) passes <= 0;
    else if (mem_rd_en && mem_addr == 0) passes <= passes + 1;
    if (mem_rd_en)
      rdq <= img[mem_addr] ^ ((mem_addr == 0 && passes < k_fail) ? 8'h01 : 8'h00);
  end
  assign mem_rd_data = rdq;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic top = c[15] ^ img[i][b];
        c = {c[14:0], 1'b0} ^ (top ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  // R4 / R5 / R6: every write checked against the image and the attempt count
  always @(negedge clk) begin
    if (rst_n && cfg_wr_en) begin
      if (wr_idx < WORDS) begin
        chk("R4", "write address", int'(cfg_wr_addr), wr_idx);
        chk("R4", "write data", int'(cfg_wr_data), int'(img[wr_idx]));
        chk("R5", "check passes before load", passes, exp_att + 1);
      end else begin
        chk("R4", "surplus write", wr_idx, WORDS - 3);
      end
      wr_idx++;
    end
  end

  task automatic prep(int k, bit bad);
    logic [15:0] c;
    for (int i = 0; i < WORDS - 2; i++) img[i] = 8'($urandom);
    c = crc_ref(WORDS - 2);
    img[WORDS-2] = c[15:8];
    img[WORDS-1] = c[7:0] ^ (bad ? 8'h5A : 8'h00);
    k_fail  = k;
    exp_att = bad ? 8 : k + 1;
    wr_idx  = 0;
  endtask

  task automatic pulse_swr();
    @(negedge clk) sw_reset = 1'b1;
    @(negedge clk) sw_reset = 1'b0;
  endtask

  task automatic finish_case(int exp_cnt, bit exp_flag);
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk("R8", "done seen before timeout", int'(done), 1);
    chk("R4", "writes completed at done", wr_idx, WORDS - 2);
    stat_rd_addr = 9'h0FE;
    #1;
    chk("R5", "failure count", int'(stat_rd_data[7:5]), exp_cnt);
    chk("R6", "failure flag", int'(stat_rd_data[0]), int'(exp_flag));
    chk("R7", "status pad bits", int'(stat_rd_data[4:1]), 0);
    @(negedge clk);
    chk("R8", "done one cycle", int'(done), 0);
    repeat (6) @(negedge clk);
    chk("R8", "no writes after done", wr_idx, WORDS - 2);
    chk("R8", "done stays low", int'(done), 0);
    chk("R10", "status held after done", int'(stat_rd_data),
        (exp_cnt << 5) | int'(exp_flag));
    stat_rd_addr = 9'($urandom);
    if (stat_rd_addr == 9'h0FE) stat_rd_addr = 9'h0FF;
    #1;
    chk("R7", "other status address", int'(stat_rd_data), 0);
  endtask

  task automatic run_case(int k, bit bad);
    prep(k, bad);
    pulse_swr();
    finish_case(bad ? 7 : k, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'h0C0FFEE5));
    rst_n = 1'b0; sw_reset = 1'b0; stat_rd_addr = 9'h0FE;
    prep(0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "write strobe in reset", int'(cfg_wr_en), 0);
    chk("R1", "status in reset", int'(stat_rd_data), 0);
    rst_n = 1'b1;
    // R2: correct image passes on the first attempt
    finish_case(0, 1'b0);
    // R5: seven corrupted reads, pass on attempt eight
    run_case(7, 1'b0);
    // R6: bad stored CRC, all eight attempts fail, image still loaded
    run_case(0, 1'b1);
    run_case(1, 1'b0);
    // R9: software reset in the middle of the retries
    prep(0, 1'b1);
    pulse_swr();
    stat_rd_addr = 9'h0FE;
    t = 0;
    while (stat_rd_data[7:5] < 3'd2 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk("R10", "count grew during retries", int'(stat_rd_data[7:5] >= 3'd2), 1);
    chk("R4", "no writes during check", wr_idx, 0);
    prep(2, 1'b0);
    pulse_swr();
    #1;
    chk("R9", "status cleared by sw_reset", int'(stat_rd_data), 0);
    finish_case(2, 1'b0);
    // random cases
    for (int n = 0; n < 6; n++) begin
      int  k   = int'($urandom % 8);
      bit  bad = ($urandom % 4) == 0;
      run_case(k, bad);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule